// File: doc/BRIEF.md
# Transactional Message Receive Queue

This block buffers complete multi-word messages between a producer that streams words and a consumer that takes whole messages. The producer raises `wr_start`, sends up to `2**MSG_WORDS_LOG2` words with `wr_valid`, and then closes the message with `wr_commit` or `wr_abort`. Only a committed message becomes visible to the consumer. An aborted message leaves the write slot where it was, and the next message overwrites it. The consumer reads any word of the oldest message through `rd_sel`/`rd_data` and retires that message with `rd_ack`.

The number of slots in use is chosen at run time with `cfg_depth`. It may be any value from zero to `MAX_SLOTS`, and it is changed only while the queue is empty and idle. Four event flags record new arrivals, crossing of a programmable watermark, reaching full, and loss of a message. Each flag latches on the rising edge of its condition and stays set until software writes a 1 to its bit. The interrupt line combines the flags that are set with a per-bit enable mask.

Top module: `msg_rx_fifo`

## Requirements
- R1: After reset the level is 0, `rd_empty` is 1, all four flags are 0 and `irq` is 0.
- R2: Each committed message raises the level by one and sets flag bit 0 (new message). The consumer sees messages in commit order, with word k of a message at `rd_sel` = k, and each `rd_ack` retires the oldest message.
- R3: An abort leaves the level and the write slot unchanged. A `wr_start` issued while a message is still open aborts the open message. Words left by an aborted message are overwritten by the next message stored in that slot.
- R4: A message whose `wr_start` arrives while the level equals the depth is discarded when it commits. This sets flag bit 3 (lost) and leaves the level and the stored messages unchanged.
- R5: With `cfg_depth` = 0, every committed message is discarded, flag bit 3 sets, the level stays 0, and flag bit 2 never sets.
- R6: Flag bit 1 (watermark) sets when the level rises to `cfg_wmark` or above. It never sets when `cfg_wmark` is 0 or greater than the depth.
- R7: Flag bit 2 (full) sets when the level becomes equal to a nonzero depth.
- R8: Flags set only on a rising condition, so a condition that stays true does not set its flag again after a clear. When `flag_clr_we` is high, a 1 in `flag_clr` clears that bit and a 0 has no effect. A set and a clear of the same bit in one cycle leave the bit at 1.
- R9: `irq` is 1 exactly when some flag bit and the matching `irq_en` bit are both 1.
- R10: `rd_ack` on an empty queue changes nothing. The read and write slots wrap modulo the configured depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | CNT_W | Slots in use (0..MAX_SLOTS; larger values are clamped) |
| cfg_wmark | input | CNT_W | Watermark level; 0 disables the watermark flag |
| wr_start | input | 1 | Opens a new message |
| wr_valid | input | 1 | Word strobe for the open message |
| wr_data | input | WORD_W | Message word |
| wr_commit | input | 1 | Closes and stores the open message |
| wr_abort | input | 1 | Closes and discards the open message |
| rd_ack | input | 1 | Retires the oldest message |
| rd_sel | input | MSG_WORDS_LOG2 | Word select within the oldest message |
| rd_data | output | WORD_W | Selected word of the oldest message |
| rd_empty | output | 1 | No message stored |
| rd_level | output | CNT_W | Number of stored messages |
| flag_clr_we | input | 1 | Strobe for `flag_clr` |
| flag_clr | input | 4 | Write-one-to-clear mask: bit0 new, bit1 watermark, bit2 full, bit3 lost |
| irq_en | input | 4 | Interrupt enable per flag bit |
| flags | output | 4 | Event flags: bit0 new, bit1 watermark, bit2 full, bit3 lost |
| irq | output | 1 | OR of enabled flags |

## Verification
A put index that moves on an abort shows up at the next read: it exposes a stale or empty slot in place of the expected message, or it shifts the order of later messages at `rd_data`. A wrong level shows up at once on `rd_level`. Within a few messages it also sets the full, watermark or lost flags at the wrong time. Flags driven by level rather than by edges reappear on the cycle after a clear. A clear that wins over a set leaves bit 0 low directly after the commit.

// File: rtl/msg_rx_fifo.sv
module msg_rx_fifo #(
  parameter int WORD_W         = 16,
  parameter int MAX_SLOTS      = 8,
  parameter int MSG_WORDS_LOG2 = 2,
  localparam int CNT_W = $clog2(MAX_SLOTS + 1),
  localparam int IDX_W = $clog2(MAX_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W-1:0]          cfg_depth,
  input  logic [CNT_W-1:0]          cfg_wmark,
  input  logic                      wr_start,
  input  logic                      wr_valid,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic                      wr_commit,
  input  logic                      wr_abort,
  input  logic                      rd_ack,
  input  logic [MSG_WORDS_LOG2-1:0] rd_sel,
  output logic [WORD_W-1:0]         rd_data,
  output logic                      rd_empty,
  output logic [CNT_W-1:0]          rd_level,
  input  logic                      flag_clr_we,
  input  logic [3:0]                flag_clr,
  input  logic [3:0]                irq_en,
  output logic [3:0]                flags,
  output logic                      irq
);
  localparam int MSG_WORDS = 1 << MSG_WORDS_LOG2;
  localparam int WCNT_W    = MSG_WORDS_LOG2 + 1;
  localparam int MEM_N     = 1 << (IDX_W + MSG_WORDS_LOG2);

  logic [WORD_W-1:0] mem [MEM_N];
  logic [CNT_W-1:0]  level, level_nx, depth;
  logic [IDX_W-1:0]  put, get;
  logic [WCNT_W-1:0] widx, widx_eff;
  logic              busy, drop, full_now, take_word, end_ok, push, lost, pop;
  logic [3:0]        set_vec;

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] i,
                                                 input logic [CNT_W-1:0] d);
    return (CNT_W'(i) + CNT_W'(1) >= d) ? '0 : i + IDX_W'(1);
  endfunction

  function automatic logic wm_hit(input logic [CNT_W-1:0] l);
    return cfg_wmark != '0 && cfg_wmark <= depth && l >= cfg_wmark;
  endfunction

  function automatic logic full_hit(input logic [CNT_W-1:0] l);
    return depth != '0 && l == depth;
  endfunction

  assign depth     = (cfg_depth > CNT_W'(MAX_SLOTS)) ? CNT_W'(MAX_SLOTS) : cfg_depth;
  assign full_now  = level >= depth;
  assign widx_eff  = wr_start ? '0 : widx;
  assign take_word = wr_valid && (wr_start ? !full_now : (busy && !drop))
                     && widx_eff < WCNT_W'(MSG_WORDS);
  assign end_ok    = busy && !wr_start;
  assign push      = end_ok && wr_commit && !drop;
  assign lost      = end_ok && wr_commit && drop;
  assign pop       = rd_ack && level != '0;
  assign level_nx  = level + CNT_W'(push) - CNT_W'(pop);

  assign set_vec = {lost,
                    full_hit(level_nx) && !full_hit(level),
                    wm_hit(level_nx) && !wm_hit(level),
                    push};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      drop  <= 1'b0;
      widx  <= '0;
      put   <= '0;
      get   <= '0;
      level <= '0;
      flags <= '0;
    end else begin
      if (wr_start) begin
        busy <= 1'b1;
        drop <= full_now;
      end else if (end_ok && (wr_commit || wr_abort)) begin
        busy <= 1'b0;
      end
      if (wr_start)       widx <= take_word ? WCNT_W'(1) : '0;
      else if (take_word) widx <= widx + WCNT_W'(1);
      if (push) put <= step_idx(put, depth);
      if (pop)  get <= step_idx(get, depth);
      level <= level_nx;
      flags <= (flags & ~(flag_clr_we ? flag_clr : 4'b0)) | set_vec;
    end
  end

  always_ff @(posedge clk) begin
    if (take_word) mem[{put, widx_eff[MSG_WORDS_LOG2-1:0]}] <= wr_data;
  end

  assign rd_data  = mem[{get, rd_sel}];
  assign rd_empty = level == '0;
  assign rd_level = level;
  assign irq      = |(flags & irq_en);

  assert_abort_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_abort && !wr_commit && !wr_start && !rd_ack |=> rd_level == $past(rd_level));

  assert_drop_lost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && drop && wr_commit && !wr_start |=> flags[3]);

  assert_zero_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    depth == '0 && rd_level == '0 && (!busy || drop) |=> rd_level == '0);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> flags[0]);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr_we && flag_clr[0] && !push |=> !flags[0]);

  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack && rd_empty && !push |=> rd_empty);
endmodule

// File: tb/msg_rx_fifo_tb.sv
module msg_rx_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W = 16;
  localparam int MAX_SLOTS = 8;
  localparam int MWL = 2;
  localparam int NW = 1 << MWL;
  localparam int CNT_W = $clog2(MAX_SLOTS + 1);

  typedef logic [NW*WORD_W-1:0] msg_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_depth, cfg_wmark, rd_level;
  logic wr_start, wr_valid, wr_commit, wr_abort, rd_ack, rd_empty, flag_clr_we, irq;
  logic [WORD_W-1:0] wr_data, rd_data;
  logic [MWL-1:0] rd_sel;
  logic [3:0] flag_clr, irq_en, flags;

  msg_rx_fifo #(.WORD_W(WORD_W), .MAX_SLOTS(MAX_SLOTS), .MSG_WORDS_LOG2(MWL)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_wmark(cfg_wmark),
    .wr_start(wr_start), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_abort(wr_abort), .rd_ack(rd_ack), .rd_sel(rd_sel),
    .rd_data(rd_data), .rd_empty(rd_empty), .rd_level(rd_level),
    .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .irq_en(irq_en),
    .flags(flags), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  msg_t exp_q[$];
  int mdepth, mwm, mlevel;
  logic [3:0] mflags, men;
  bit mdrop;

  function automatic bit wm_on(int l);
    return mwm != 0 && mwm <= mdepth && l >= mwm;
  endfunction
  function automatic bit full_on(int l);
    return mdepth != 0 && l == mdepth;
  endfunction
  function automatic void level_to(int nl);
    if (wm_on(nl) && !wm_on(mlevel)) mflags[1] = 1'b1;
    if (full_on(nl) && !full_on(mlevel)) mflags[2] = 1'b1;
    mlevel = nl;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_state(string tag);
    check({tag, " level"}, int'(rd_level), mlevel);
    check({tag, " flags"}, int'(flags), int'(mflags));
    check({tag, " irq"}, int'(irq), int'(|(mflags & men)));
    check({tag, " empty"}, int'(rd_empty), int'(mlevel == 0));
  endtask

  task automatic send(int seed, int kind, logic [3:0] clr);
    msg_t m = '0;
    wr_start = 1; step(); wr_start = 0;
    mdrop = (mlevel >= mdepth);
    for (int k = 0; k < NW; k++) begin
      wr_valid = 1; wr_data = WORD_W'(seed * 16 + k);
      m[k*WORD_W +: WORD_W] = wr_data;
      step();
    end
    wr_valid = 0;
    if (kind == 0) begin
      wr_commit = 1; flag_clr_we = (clr != 0); flag_clr = clr;
      step();
      wr_commit = 0; flag_clr_we = 0; flag_clr = 0;
      mflags &= ~clr;
      if (mdrop) mflags[3] = 1'b1;
      else begin
        exp_q.push_back(m);
        mflags[0] = 1'b1;
        level_to(mlevel + 1);
      end
    end else if (kind == 1) begin
      wr_abort = 1; step(); wr_abort = 0;
    end
  endtask

  task automatic clear(logic [3:0] c);
    flag_clr_we = 1; flag_clr = c; step(); flag_clr_we = 0; flag_clr = 0;
    mflags &= ~c;
  endtask

  // monitor side of the scoreboard: compares the oldest message, then retires it
  task automatic pop(string tag);
    if (exp_q.size() != 0) begin
      msg_t m = exp_q.pop_front();
      for (int s = 0; s < NW; s++) begin
        rd_sel = MWL'(s); #1;
        check(tag, int'(rd_data), int'(m[s*WORD_W +: WORD_W]));
      end
      level_to(mlevel - 1);
    end
    rd_ack = 1; step(); rd_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      miscompares++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    wr_start = 0; wr_valid = 0; wr_data = '0; wr_commit = 0; wr_abort = 0;
    rd_ack = 0; rd_sel = '0; flag_clr_we = 0; flag_clr = 0;
    cfg_depth = 4; cfg_wmark = 2; irq_en = 4'hF;
    mdepth = 4; mwm = 2; mlevel = 0; mflags = 0; men = 4'hF;
    step(); step(); rst_n = 1; step();
    check_state("R1 reset");

    send(1, 0, 0); send(2, 0, 0);
    check_state("R2 R6 two commits");
    clear(4'b0001);   check_state("R8 clear bit0");
    clear(4'b0000);   check_state("R8 write zero");

    send(3, 1, 0);    check_state("R3 abort");
    send(4, 2, 0); send(5, 0, 0);
    check_state("R3 restart aborts open message");

    send(6, 0, 0);    check_state("R7 full");
    send(7, 0, 0);    check_state("R4 lost when full");

    pop("R2 order msg1"); pop("R2 order msg2");
    pop("R3 overwrite msg5"); pop("R4 stored intact msg6");
    check_state("R2 drained");
    pop("R10 empty pop");
    check_state("R10 empty pop ignored");

    clear(4'hF);
    for (int i = 0; i < 6; i++) begin
      send(10 + i, 0, 0);
      pop("R10 wrap data");
    end
    check_state("R10 wrap state");

    send(20, 0, 4'b0001); check_state("R8 set wins over clear");
    send(21, 0, 0);       check_state("R6 watermark reached");
    clear(4'b0010);
    send(22, 0, 0);       check_state("R8 edge only, no re-set");

    men = 4'b0010; irq_en = men; #1; check_state("R9 masked irq");
    men = 4'b0001; irq_en = men; #1; check_state("R9 enabled irq");
    men = 4'hF; irq_en = men;

    pop("R2 drain"); pop("R2 drain"); pop("R2 drain");
    clear(4'hF);
    cfg_wmark = 0; mwm = 0;
    for (int i = 0; i < 4; i++) send(30 + i, 0, 0);
    check_state("R6 watermark zero disabled");
    for (int i = 0; i < 4; i++) pop("R6 drain");
    clear(4'hF);
    cfg_wmark = 5; mwm = 5;
    for (int i = 0; i < 4; i++) send(34 + i, 0, 0);
    check_state("R6 watermark above depth disabled");
    for (int i = 0; i < 4; i++) pop("R6 drain");
    clear(4'hF);

    cfg_depth = 0; mdepth = 0;
    send(40, 0, 0);   check_state("R5 depth zero lost");
    send(41, 0, 0);   check_state("R5 depth zero second");
    pop("R5 empty pop"); check_state("R5 stays empty");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule